// File: doc/BRIEF.md
# Power Product and Peak Tracker

This block forms an instantaneous power figure for each of several measurement channels by multiplying an unsigned 12-bit voltage code by an unsigned 12-bit current-sense code. The result is kept as a raw 24-bit product. No scaling is applied, so downstream logic or software divides by the sense resistance to get watts. A two-bit source code picks the voltage factor. The factor is either the channel's supply-sense code or its general-purpose analog input code. The source code is shared by all channels.

Every valid sample updates the product register. It also widens a running minimum and maximum for that channel. The product is compared with an upper and a lower threshold held in registers inside the block. A violation sets a sticky flag that stays up until it is cleared. A one-cycle peak-reset request returns both peak registers to their start values, so the next sample seeds them. The voltage codes may come from a lower-resolution conversion. In that case they are already scaled to 12-bit weight, and the block treats them the same way.

Top module: `pwr_peak_tracker`

## Requirements
- R1: On a clock edge with `sample_vld` high, each channel's `power` slice becomes the 24-bit unsigned product of its selected voltage code and its current code, visible after that edge. With `sample_vld` low, `power`, `power_max` and `power_min` keep their values.
- R2: With `vsrc_sel` 2'b00 or 2'b01, channel n uses supply code n. With 2'b10 or 2'b11, channel n uses GPIO code n. Channel n always uses current code n. Channel n occupies bits [n*12 +: 12] of each code bus and [n*24 +: 24] of each 24-bit bus.
- R3: After reset, `power` is 0, `power_max` is 0, `power_min` is 0xFFFFFF, both flag vectors are 0, the upper threshold is 0xFFFFFF and the lower threshold is 0x000000. With these thresholds, neither a full-scale product nor a zero product raises a flag.
- R4: A clock edge with `thr_load` high copies `thr_upper` and `thr_lower` into the threshold registers. A sample taken on that same edge is still compared with the previous thresholds.
- R5: A clock edge with `peak_clr` high loads `power_max` with 0 and `power_min` with 0xFFFFFF. This takes priority over a sample on the same edge, and the request has no lasting effect after that edge.
- R6: On a sample edge without `peak_clr`, `power_max` takes the new product when it is greater than `power_max`, and `power_min` takes it when it is less than `power_min`.
- R7: On a sample edge, `over_flag[n]` is set when the product is greater than the upper threshold, and `under_flag[n]` is set when it is less than the lower threshold.
- R8: Flags stay set until an edge with `flag_clr` high. If a new violation arrives on the same edge as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | New codes valid this cycle |
| vsrc_sel | input | 2 | Voltage factor source code, shared by all channels |
| supply_code | input | NUM_CH*12 | Supply-sense voltage codes |
| gpio_code | input | NUM_CH*12 | General-purpose analog input codes |
| isense_code | input | NUM_CH*12 | Current-sense codes |
| peak_clr | input | 1 | One-cycle request to restart min/max tracking |
| flag_clr | input | 1 | Clears the sticky threshold flags |
| thr_load | input | 1 | Loads the threshold registers |
| thr_upper | input | NUM_CH*24 | Upper threshold values to load |
| thr_lower | input | NUM_CH*24 | Lower threshold values to load |
| power | output | NUM_CH*24 | Latest product per channel |
| power_max | output | NUM_CH*24 | Running maximum per channel |
| power_min | output | NUM_CH*24 | Running minimum per channel |
| over_flag | output | NUM_CH | Sticky above-upper-threshold flag |
| under_flag | output | NUM_CH | Sticky below-lower-threshold flag |

## Verification
All four source codes are applied with supply and GPIO codes that differ on purpose. A wrong mux slice or a swapped channel therefore shows up as a wrong product. Full-scale and zero operands test the product width and the default thresholds at their edges. Rising and then falling products show whether the min and max registers move only in the correct direction. Edges that combine two events test each priority rule: a peak clear with a sample, a flag clear with a new violation, and a threshold load with a sample.

// File: rtl/pwr_trk_pkg.sv
package pwr_trk_pkg;

   typedef enum logic [1:0] {
      VSRC_SUPPLY_0 = 2'b00,
      VSRC_SUPPLY_1 = 2'b01,
      VSRC_GPIO_0   = 2'b10,
      VSRC_GPIO_1   = 2'b11
   } vsrc_e;

   // Upper bit of the source code selects the GPIO factor.
   function automatic logic vsrc_is_gpio(input vsrc_e sel);
      return (sel == VSRC_GPIO_0) || (sel == VSRC_GPIO_1);
   endfunction

endpackage

// File: rtl/pwr_src_sel.sv
module pwr_src_sel
   import pwr_trk_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic [1:0]        sel,
   input  logic [CODE_W-1:0] supply_in,
   input  logic [CODE_W-1:0] gpio_in,
   output logic [CODE_W-1:0] volt_out
);

   vsrc_e sel_e;

   always_comb begin
      sel_e    = vsrc_e'(sel);
      volt_out = vsrc_is_gpio(sel_e) ? gpio_in : supply_in;
   end

endmodule

// File: rtl/pwr_mul.sv
module pwr_mul #(
   parameter int CODE_W    = 12,
   parameter int P_W       = 24,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic [CODE_W-1:0] volt,
   input  logic [CODE_W-1:0] curr,
   output logic [P_W-1:0]    prod
);

   generate
      if (SHIFT_ADD) begin : g_shift_add
         always_comb begin
            prod = '0;
            for (int b = 0; b < CODE_W; b++) begin
               if (curr[b]) prod = prod + (P_W'(volt) << b);
            end
         end
      end else begin : g_direct
         always_comb prod = P_W'(volt) * P_W'(curr);
      end
   endgenerate

endmodule

// File: rtl/pwr_track.sv
module pwr_track #(
   parameter int P_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   input  logic [P_W-1:0] prod,
   input  logic           peak_clr,
   input  logic           flag_clr,
   input  logic           thr_ld,
   input  logic [P_W-1:0] thr_hi_in,
   input  logic [P_W-1:0] thr_lo_in,
   output logic [P_W-1:0] power,
   output logic [P_W-1:0] pmax,
   output logic [P_W-1:0] pmin,
   output logic           over,
   output logic           under
);

   localparam logic [P_W-1:0] ALL_ONES = {P_W{1'b1}};

   logic [P_W-1:0] thr_hi_q, thr_lo_q;
   logic           over_hit, under_hit;

   always_comb begin
      over_hit  = smp_vld && (prod > thr_hi_q);
      under_hit = smp_vld && (prod < thr_lo_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_hi_q <= ALL_ONES;
         thr_lo_q <= '0;
      end else if (thr_ld) begin
         thr_hi_q <= thr_hi_in;
         thr_lo_q <= thr_lo_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         power <= '0;
      end else if (smp_vld) begin
         power <= prod;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmax <= '0;
         pmin <= ALL_ONES;
      end else if (peak_clr) begin
         pmax <= '0;
         pmin <= ALL_ONES;
      end else if (smp_vld) begin
         if (prod > pmax) pmax <= prod;
         if (prod < pmin) pmin <= prod;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         over  <= 1'b0;
         under <= 1'b0;
      end else begin
         over  <= over_hit  | (over  & ~flag_clr);
         under <= under_hit | (under & ~flag_clr);
      end
   end

   AST_POWER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(power)); // R1
   AST_PEAK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      peak_clr |=> (pmax == '0) && (pmin == ALL_ONES)); // R5
   AST_MAX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_clr |=> pmax >= $past(pmax)); // R6
   AST_MIN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_clr |=> pmin <= $past(pmin)); // R6
   AST_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && (prod > thr_hi_q)) |=> over); // R7
   AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && (prod < thr_lo_q)) |=> under); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (over && !flag_clr) |=> over); // R8

endmodule

// File: rtl/pwr_peak_tracker.sv
module pwr_peak_tracker #(
   parameter int NUM_CH    = 2,
   parameter int CODE_W    = 12,
   parameter int P_W       = 24,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sample_vld,
   input  logic [1:0]               vsrc_sel,
   input  logic [NUM_CH*CODE_W-1:0] supply_code,
   input  logic [NUM_CH*CODE_W-1:0] gpio_code,
   input  logic [NUM_CH*CODE_W-1:0] isense_code,
   input  logic                     peak_clr,
   input  logic                     flag_clr,
   input  logic                     thr_load,
   input  logic [NUM_CH*P_W-1:0]    thr_upper,
   input  logic [NUM_CH*P_W-1:0]    thr_lower,
   output logic [NUM_CH*P_W-1:0]    power,
   output logic [NUM_CH*P_W-1:0]    power_max,
   output logic [NUM_CH*P_W-1:0]    power_min,
   output logic [NUM_CH-1:0]        over_flag,
   output logic [NUM_CH-1:0]        under_flag
);

   generate
      if (P_W != 2*CODE_W) begin : g_bad_width
         $error("pwr_peak_tracker: P_W must equal 2*CODE_W");
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("pwr_peak_tracker: NUM_CH must be at least 1");
      end
   endgenerate

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [CODE_W-1:0] volt;
         logic [P_W-1:0]    prod;

         pwr_src_sel #(.CODE_W(CODE_W)) u_sel (
            .sel       (vsrc_sel),
            .supply_in (supply_code[ch*CODE_W +: CODE_W]),
            .gpio_in   (gpio_code[ch*CODE_W +: CODE_W]),
            .volt_out  (volt)
         );

         pwr_mul #(.CODE_W(CODE_W), .P_W(P_W), .SHIFT_ADD(SHIFT_ADD)) u_mul (
            .volt (volt),
            .curr (isense_code[ch*CODE_W +: CODE_W]),
            .prod (prod)
         );

         pwr_track #(.P_W(P_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_vld   (sample_vld),
            .prod      (prod),
            .peak_clr  (peak_clr),
            .flag_clr  (flag_clr),
            .thr_ld    (thr_load),
            .thr_hi_in (thr_upper[ch*P_W +: P_W]),
            .thr_lo_in (thr_lower[ch*P_W +: P_W]),
            .power     (power[ch*P_W +: P_W]),
            .pmax      (power_max[ch*P_W +: P_W]),
            .pmin      (power_min[ch*P_W +: P_W]),
            .over      (over_flag[ch]),
            .under     (under_flag[ch])
         );
      end
   endgenerate

endmodule

// File: tb/tb_pwr_peak_tracker.sv
`timescale 1ns/1ps
module tb_pwr_peak_tracker;

   localparam int NCH = 2;
   localparam int CW  = 12;
   localparam int PW  = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sample_vld = 1'b0;
   logic [1:0] vsrc_sel = 2'b00;
   logic [NCH*CW-1:0] supply_code = '0, gpio_code = '0, isense_code = '0;
   logic peak_clr = 1'b0, flag_clr = 1'b0, thr_load = 1'b0;
   logic [NCH*PW-1:0] thr_upper = '0, thr_lower = '0;
   logic [NCH*PW-1:0] power, power_max, power_min;
   logic [NCH-1:0] over_flag, under_flag;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pwr_peak_tracker dut (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .vsrc_sel(vsrc_sel),
      .supply_code(supply_code), .gpio_code(gpio_code), .isense_code(isense_code),
      .peak_clr(peak_clr), .flag_clr(flag_clr), .thr_load(thr_load),
      .thr_upper(thr_upper), .thr_lower(thr_lower),
      .power(power), .power_max(power_max), .power_min(power_min),
      .over_flag(over_flag), .under_flag(under_flag)
   );

   typedef struct {
      string          tag;
      logic [PW-1:0]  pw [NCH];
      logic [PW-1:0]  mx [NCH];
      logic [PW-1:0]  mn [NCH];
      logic           ov [NCH];
      logic           un [NCH];
   } exp_t;

   exp_t exp_q [$];

   // reference state held by the bench
   logic [PW-1:0] m_pw [NCH], m_mx [NCH], m_mn [NCH], m_hi [NCH], m_lo [NCH];
   logic          m_ov [NCH], m_un [NCH];

   task automatic chk(string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_pw[c] = '0; m_mx[c] = '0; m_mn[c] = 24'hFFFFFF;
         m_hi[c] = 24'hFFFFFF; m_lo[c] = '0; m_ov[c] = 1'b0; m_un[c] = 1'b0;
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(input string tag, input bit s, input bit pk, input bit fc,
                       input bit ld, input logic [1:0] sel,
                       input logic [CW-1:0] s0, input logic [CW-1:0] s1,
                       input logic [CW-1:0] g0, input logic [CW-1:0] g1,
                       input logic [CW-1:0] i0, input logic [CW-1:0] i1,
                       input logic [PW-1:0] hi, input logic [PW-1:0] lo);
      exp_t e;
      logic [CW-1:0] sv [NCH], gv [NCH], iv [NCH];
      logic [PW-1:0] p;
      @(negedge clk);
      sample_vld = s; peak_clr = pk; flag_clr = fc; thr_load = ld; vsrc_sel = sel;
      supply_code = {s1, s0}; gpio_code = {g1, g0}; isense_code = {i1, i0};
      thr_upper = {hi, hi}; thr_lower = {lo, lo};
      sv[0] = s0; sv[1] = s1; gv[0] = g0; gv[1] = g1; iv[0] = i0; iv[1] = i1;
      for (int c = 0; c < NCH; c++) begin
         p = PW'(sel[1] ? gv[c] : sv[c]) * PW'(iv[c]);
         if (s) m_pw[c] = p;
         if (pk) begin
            m_mx[c] = '0; m_mn[c] = 24'hFFFFFF;
         end else if (s) begin
            if (p > m_mx[c]) m_mx[c] = p;
            if (p < m_mn[c]) m_mn[c] = p;
         end
         m_ov[c] = (s && (p > m_hi[c])) | (m_ov[c] & ~fc);
         m_un[c] = (s && (p < m_lo[c])) | (m_un[c] & ~fc);
         if (ld) begin
            m_hi[c] = hi; m_lo[c] = lo;
         end
      end
      e.tag = tag;
      for (int c = 0; c < NCH; c++) begin
         e.pw[c] = m_pw[c]; e.mx[c] = m_mx[c]; e.mn[c] = m_mn[c];
         e.ov[c] = m_ov[c]; e.un[c] = m_un[c];
      end
      exp_q.push_back(e);
   endtask

   // monitor: compares after the edge that follows each queued cycle
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            for (int c = 0; c < NCH; c++) begin
               chk(e.tag, $sformatf("power[%0d]", c), power[c*PW +: PW], e.pw[c]);
               chk(e.tag, $sformatf("max[%0d]", c), power_max[c*PW +: PW], e.mx[c]);
               chk(e.tag, $sformatf("min[%0d]", c), power_min[c*PW +: PW], e.mn[c]);
               chk(e.tag, $sformatf("over[%0d]", c), PW'(over_flag[c]), PW'(e.ov[c]));
               chk(e.tag, $sformatf("under[%0d]", c), PW'(under_flag[c]), PW'(e.un[c]));
            end
         end
      end
   end

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: reset values at the ports
      for (int c = 0; c < NCH; c++) begin
         chk("R3", "reset power", power[c*PW +: PW], '0);
         chk("R3", "reset max", power_max[c*PW +: PW], '0);
         chk("R3", "reset min", power_min[c*PW +: PW], 24'hFFFFFF);
         chk("R3", "reset over", PW'(over_flag[c]), '0);
         chk("R3", "reset under", PW'(under_flag[c]), '0);
      end
      // R1 R2 R6: supply source, several codes
      step("R2", 1,0,0,0, 2'b00, 12'd100, 12'd7, 12'd900, 12'd800, 12'd50, 12'd3, '0, '0);
      step("R2", 1,0,0,0, 2'b01, 12'd300, 12'd9, 12'd11, 12'd13, 12'd40, 12'd5, '0, '0);
      step("R2", 1,0,0,0, 2'b10, 12'd300, 12'd9, 12'd17, 12'd19, 12'd40, 12'd5, '0, '0);
      step("R2", 1,0,0,0, 2'b11, 12'd300, 12'd9, 12'd600, 12'd2, 12'd61, 12'd4000, '0, '0);
      // R3: default thresholds at full scale and zero
      step("R3", 1,0,0,0, 2'b00, 12'hFFF, 12'hFFF, 12'd0, 12'd0, 12'hFFF, 12'hFFF, '0, '0);
      step("R3", 1,0,0,0, 2'b00, 12'd0, 12'd5, 12'd0, 12'd0, 12'd77, 12'd0, '0, '0);
      // R1: idle cycles hold all values
      step("R1", 0,0,0,0, 2'b10, 12'd1, 12'd2, 12'd3, 12'd4, 12'd5, 12'd6, '0, '0);
      step("R1", 0,0,0,0, 2'b00, 12'hABC, 12'h123, 12'd3, 12'd4, 12'h0F0, 12'd6, '0, '0);
      // R5: clear with a sample on the same edge, then reseed
      step("R5", 1,1,0,0, 2'b00, 12'd20, 12'd30, 12'd0, 12'd0, 12'd10, 12'd10, '0, '0);
      step("R5", 1,0,0,0, 2'b00, 12'd20, 12'd30, 12'd0, 12'd0, 12'd10, 12'd10, '0, '0);
      // R6: rising then falling products
      step("R6", 1,0,0,0, 2'b00, 12'd40, 12'd3, 12'd0, 12'd0, 12'd10, 12'd10, '0, '0);
      step("R6", 1,0,0,0, 2'b00, 12'd5, 12'd100, 12'd0, 12'd0, 12'd10, 12'd10, '0, '0);
      step("R6", 1,0,0,0, 2'b00, 12'd25, 12'd25, 12'd0, 12'd0, 12'd10, 12'd10, '0, '0);
      // R4: load with a sample on the same edge uses the old limits
      step("R4", 1,0,0,1, 2'b00, 12'd200, 12'd1, 12'd0, 12'd0, 12'd10, 12'd1, 24'd1000, 24'd100);
      // R7: over and under against the loaded limits
      step("R7", 1,0,0,0, 2'b00, 12'd200, 12'd50, 12'd0, 12'd0, 12'd10, 12'd2, '0, '0);
      step("R7", 1,0,0,0, 2'b00, 12'd5, 12'd5, 12'd0, 12'd0, 12'd10, 12'd100, '0, '0);
      // R8: sticky, clear with coincident violation, plain clear
      step("R8", 0,0,0,0, 2'b00, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, '0, '0);
      step("R8", 1,0,1,0, 2'b00, 12'd200, 12'd50, 12'd0, 12'd0, 12'd10, 12'd3, '0, '0);
      step("R8", 0,0,1,0, 2'b00, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, '0, '0);
      step("R8", 0,0,0,0, 2'b00, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, 12'd0, '0, '0);
      @(negedge clk);
      sample_vld = 1'b0; peak_clr = 1'b0; flag_clr = 1'b0; thr_load = 1'b0;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule